// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block drives the control pins of a 256-pixel linear photodiode array with a pixel data-hold stage. The array is built from two 128-pixel halves that are chained in series. For each frame the block raises a start pulse and then runs exactly N+1 sensor clock cycles, where N is the pixel count. While the pixels shift out, it produces one sample strobe per pixel, each with a pixel index, for a downstream converter. The data shifted out in a frame was collected during the previous exposure. The first reported frame after power-up therefore carries a flag saying its exposure window was the flush frame.

The sensor clock half period is set in system clock cycles and is raised to a floor value (`MIN_HALF`) so that the high and low phases never fall below the sensor's limit. The integration time is also counted in system clock cycles, from one start pulse to the next. It is held between a lower bound and an upper bound. The lower bound is (N-18) sensor clock periods plus a fixed charge-transfer time. The upper bound is a fixed maximum. A programmed value outside these bounds raises an error flag and is replaced by the nearer bound.

Frames are requested in one of two ways. A `start_i` pulse is held pending until the next start is allowed. A `cont_i` level repeats frames for as long as it stays high. Right after reset the block runs one flush frame of its own. That frame produces no strobes and no done pulse. The sample strobe is a valid signal with no ready: the array cannot be paused mid-line, so the consumer must accept every strobe, and no back-pressure exists.

Top module: `sls_readout_seq`

## Requirements
- R1: After reset is released, the block starts a flush frame on its own. That frame has N+1 sensor clock rising edges, produces no sample strobes and produces no done pulse.
- R2: Each frame is a start pulse on `si_o` followed by exactly N+1 rising edges on `sclk_o`. After the last edge `sclk_o` returns low. `done_o` then pulses for one cycle, at the same edge where `busy_o` falls. `busy_o` is high from the rise of `si_o` until that edge.
- R3: `si_o` rises one full half period before the first `sclk_o` rising edge. It is still high at that edge and is low before the second rising edge.
- R4: Every high phase and every low phase of `sclk_o` inside a frame, including the setup phase before the first edge, lasts H = max(`div_i`, MIN_HALF) system cycles. H is captured when the frame starts.
- R5: A non-flush frame gives exactly N strobes on `smp_stb_o`. Each strobe falls while `sclk_o` is low. `pix_idx_o` counts 0, 1, ... N-1 on successive strobes. No strobe occurs outside a frame.
- R6: The integration limit is L = `int_i`, clamped to the range [(N-18)·2H + TQT_CYC, MAX_INT]. `int_err_o` is high, one cycle after the inputs change, exactly when `int_i` lies outside that range.
- R7: With `cont_i` held high, the interval in system cycles between successive rises of `si_o` is max(L, (2N+2)·H + 1).
- R8: A `start_i` pulse is held until a start is allowed: the block is idle and at least L cycles have passed since the previous rise of `si_o`. The pulse then produces exactly one frame.
- R9: `exp_flush_o` is 1 during the strobes of the first frame after the flush frame and 0 during the strobes of later frames.
- R10: Whenever `busy_o` is low, `si_o` and `sclk_o` are low. This holds during reset as well, when the strobe and done outputs are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-frame request pulse |
| cont_i | input | 1 | Continuous-mode level |
| div_i | input | DIV_W | Sensor clock half period in system cycles |
| int_i | input | INT_W | Integration time in system cycles |
| si_o | output | 1 | Start pulse to the array |
| sclk_o | output | 1 | Sensor clock |
| smp_stb_o | output | 1 | One-cycle sample strobe per pixel |
| pix_idx_o | output | $clog2(N_PIX) | Index of the pixel being strobed |
| exp_flush_o | output | 1 | Strobed data came from the flush-frame exposure |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| int_err_o | output | 1 | Programmed integration time out of range |

## Verification
The main timing is exercised with four settings of divider and integration time, each run in continuous mode. One setting has the integration time above the frame length, which shows the integration counter setting the pace. One has a divider below the floor, which shows the half-period clamp. One has an integration value below the lower bound, where the frame length must set the pace and the error flag must rise. One has a value above the upper bound, which shows clamping to the maximum. Directed runs cover the flush frame, a single start held until the integration time has elapsed, the flag on the first frame after the flush, and the absence of any extra frame once a request has been served.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } seq_st_e;
endpackage

// File: rtl/sls_int_limit.sv
// Clamps the divider and integration settings and flags out-of-range time.
module sls_int_limit #(
  parameter int N_PIX    = 256,
  parameter int DIV_W    = 8,
  parameter int INT_W    = 25,
  parameter int MIN_HALF = 13,
  parameter int TQT_CYC  = 5000,
  parameter int MAX_INT  = 25_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [INT_W-1:0] int_i,
  output logic [DIV_W-1:0] half_o,
  output logic [INT_W-1:0] lim_o,
  output logic             err_o
);
  localparam int MULT = 2 * (N_PIX - 18);

  logic [DIV_W-1:0] half_c;
  logic [INT_W-1:0] min_c;
  logic             lo_c;
  logic             hi_c;

  always_comb begin
    half_c = (div_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : div_i;
    min_c  = INT_W'(MULT) * INT_W'(half_c) + INT_W'(TQT_CYC);
    lo_c   = int_i < min_c;
    hi_c   = int_i > INT_W'(MAX_INT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_o <= DIV_W'(MIN_HALF);
      lim_o  <= INT_W'(MAX_INT);
      err_o  <= 1'b0;
    end else begin
      half_o <= half_c;
      lim_o  <= lo_c ? min_c : (hi_c ? INT_W'(MAX_INT) : int_i);
      err_o  <= lo_c | hi_c;
    end
  end
endmodule

// File: rtl/sls_half_timer.sv
// Counts the system cycles inside one sensor clock phase.
module sls_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick,
  output logic             mid
);
  logic [DIV_W-1:0] hc;

  always_comb begin
    tick = run && (hc == half - DIV_W'(1));
    mid  = run && (hc == (half >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hc <= '0;
    else if (!run || tick) hc <= '0;
    else                   hc <= hc + DIV_W'(1);
  end
endmodule

// File: rtl/sls_int_timer.sv
// Saturating count of system cycles since the last start pulse.
module sls_int_timer #(
  parameter int INT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [INT_W-1:0] lim,
  output logic             ready
);
  logic [INT_W-1:0] cnt;

  assign ready = cnt >= lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (restart)     cnt <= INT_W'(1);
    else if (cnt != '1)   cnt <= cnt + INT_W'(1);
  end
endmodule

// File: rtl/sls_frame_ctl.sv
// Frame state machine: start pulse, N+1 clocks, strobes, flush handling.
module sls_frame_ctl
  import sls_pkg::*;
#(
  parameter int N_PIX = 256,
  parameter int DIV_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     ready,
  input  logic                     tick,
  input  logic                     mid,
  input  logic [DIV_W-1:0]         half_in,
  output logic                     go_o,
  output logic                     fl_pend_o,
  output logic                     run_o,
  output logic [DIV_W-1:0]         half_q,
  output logic                     si_o,
  output logic                     sclk_o,
  output logic                     stb_o,
  output logic [$clog2(N_PIX)-1:0] idx_o,
  output logic                     done_o,
  output logic                     busy_o,
  output logic                     exp_o
);
  localparam int IDX_W  = $clog2(N_PIX);
  localparam int EDGE_W = $clog2(N_PIX + 2);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(N_PIX + 1);

  seq_st_e           st;
  logic [EDGE_W-1:0] edge_n;
  logic              flush_pend;
  logic              flush_act;
  logic              after_flush;

  assign fl_pend_o = flush_pend;
  assign busy_o    = (st != ST_IDLE);
  assign run_o     = busy_o;
  assign go_o      = (st == ST_IDLE) && (flush_pend || (req && ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      edge_n      <= '0;
      half_q      <= '0;
      si_o        <= 1'b0;
      sclk_o      <= 1'b0;
      stb_o       <= 1'b0;
      idx_o       <= '0;
      done_o      <= 1'b0;
      exp_o       <= 1'b0;
      flush_pend  <= 1'b1;
      flush_act   <= 1'b0;
      after_flush <= 1'b0;
    end else begin
      stb_o  <= 1'b0;
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (go_o) begin
            st         <= ST_SETUP;
            si_o       <= 1'b1;
            edge_n     <= '0;
            half_q     <= half_in;
            flush_act  <= flush_pend;
            flush_pend <= 1'b0;
            if (!flush_pend) begin
              exp_o       <= after_flush;
              after_flush <= 1'b0;
            end
          end
        end
        ST_SETUP: begin
          if (tick) begin
            st     <= ST_HIGH;
            sclk_o <= 1'b1;
            edge_n <= EDGE_W'(1);
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk_o <= 1'b0;
            si_o   <= 1'b0;
            if (edge_n == LAST_EDGE) begin
              st <= ST_IDLE;
              if (flush_act) after_flush <= 1'b1;
              else           done_o      <= 1'b1;
            end else begin
              st <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (mid && !flush_act) begin
            stb_o <= 1'b1;
            idx_o <= IDX_W'(edge_n - EDGE_W'(1));
          end
          if (tick) begin
            st     <= ST_HIGH;
            sclk_o <= 1'b1;
            edge_n <= edge_n + EDGE_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sls_readout_seq.sv
// Top: linear photodiode array readout sequencer.
module sls_readout_seq #(
  parameter int N_PIX    = 256,
  parameter int DIV_W    = 8,
  parameter int INT_W    = 25,
  parameter int MIN_HALF = 13,
  parameter int TQT_CYC  = 5000,
  parameter int MAX_INT  = 25_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     cont_i,
  input  logic [DIV_W-1:0]         div_i,
  input  logic [INT_W-1:0]         int_i,
  output logic                     si_o,
  output logic                     sclk_o,
  output logic                     smp_stb_o,
  output logic [$clog2(N_PIX)-1:0] pix_idx_o,
  output logic                     exp_flush_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     int_err_o
);
  generate
    if (MIN_HALF < 3) begin : g_bad_half
      $error("MIN_HALF must be at least 3 so the strobe sits inside the low phase");
    end
  endgenerate

  logic [DIV_W-1:0] half_c;
  logic [DIV_W-1:0] half_q;
  logic [INT_W-1:0] lim;
  logic             ready;
  logic             tick;
  logic             mid;
  logic             run;
  logic             go;
  logic             fl_pend;
  logic             start_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 start_pend <= 1'b0;
    else if (go && !fl_pend)    start_pend <= 1'b0;
    else if (start_i)           start_pend <= 1'b1;
  end

  sls_int_limit #(
    .N_PIX(N_PIX), .DIV_W(DIV_W), .INT_W(INT_W),
    .MIN_HALF(MIN_HALF), .TQT_CYC(TQT_CYC), .MAX_INT(MAX_INT)
  ) u_lim (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .int_i(int_i),
    .half_o(half_c), .lim_o(lim), .err_o(int_err_o)
  );

  sls_int_timer #(.INT_W(INT_W)) u_itmr (
    .clk(clk), .rst_n(rst_n), .restart(go), .lim(lim), .ready(ready)
  );

  sls_half_timer #(.DIV_W(DIV_W)) u_htmr (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_q), .tick(tick), .mid(mid)
  );

  sls_frame_ctl #(.N_PIX(N_PIX), .DIV_W(DIV_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .req(start_pend | start_i | cont_i),
    .ready(ready), .tick(tick), .mid(mid), .half_in(half_c),
    .go_o(go), .fl_pend_o(fl_pend), .run_o(run), .half_q(half_q),
    .si_o(si_o), .sclk_o(sclk_o), .stb_o(smp_stb_o), .idx_o(pix_idx_o),
    .done_o(done_o), .busy_o(busy_o), .exp_o(exp_flush_o)
  );
endmodule

// File: rtl/sls_readout_seq_chk.sv
// Property checker bound to the sequencer top.
module sls_readout_seq_chk #(
  parameter int N_PIX = 256
) (
  input logic clk,
  input logic rst_n,
  input logic si_o,
  input logic sclk_o,
  input logic smp_stb_o,
  input logic busy_o,
  input logic done_o
);
  logic        si_d;
  logic        sclk_d;
  logic [15:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_d     <= 1'b0;
      sclk_d   <= 1'b0;
      edge_cnt <= '0;
    end else begin
      si_d   <= si_o;
      sclk_d <= sclk_o;
      if (si_o && !si_d)          edge_cnt <= '0;
      else if (sclk_o && !sclk_d) edge_cnt <= edge_cnt + 16'd1;
    end
  end

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!si_o && !sclk_o));
  p_si_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && !sclk_d && edge_cnt == 16'd0) |-> si_o);
  p_si_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && !sclk_d && edge_cnt != 16'd0) |-> !si_o);
  p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (edge_cnt == 16'(N_PIX + 1)));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_stb_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb_o |-> (!sclk_o && busy_o));
endmodule

bind sls_readout_seq sls_readout_seq_chk #(.N_PIX(N_PIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .si_o(si_o), .sclk_o(sclk_o),
  .smp_stb_o(smp_stb_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sls_readout_seq_tb.sv
module sls_readout_seq_tb;
  localparam int N_PIX = 256;
  localparam int DIV_W = 8;
  localparam int INT_W = 25;
  localparam int MIN_HALF = 13;
  localparam int TQT_CYC = 100;
  localparam int MAX_INT = 20000;

  typedef struct packed {
    logic [7:0]  div;
    logic [24:0] itv;
    logic [24:0] per;
    logic        err;
  } vec_t;

  // div, int, expected SI interval, expected error flag
  localparam vec_t VEC [0:3] = '{
    '{8'd13, 25'd9000,  25'd9000,  1'b0},
    '{8'd2,  25'd7000,  25'd7000,  1'b0},
    '{8'd14, 25'd5,     25'd7197,  1'b1},
    '{8'd13, 25'd30000, 25'd20000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cont_i = 1'b0;
  logic [DIV_W-1:0] div_i = 8'd13;
  logic [INT_W-1:0] int_i = 25'd9000;
  logic si_o, sclk_o, smp_stb_o, exp_flush_o, busy_o, done_o, int_err_o;
  logic [7:0] pix_idx_o;

  always #2 clk = ~clk;

  sls_readout_seq #(
    .N_PIX(N_PIX), .DIV_W(DIV_W), .INT_W(INT_W),
    .MIN_HALF(MIN_HALF), .TQT_CYC(TQT_CYC), .MAX_INT(MAX_INT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
    .div_i(div_i), .int_i(int_i), .si_o(si_o), .sclk_o(sclk_o),
    .smp_stb_o(smp_stb_o), .pix_idx_o(pix_idx_o), .exp_flush_o(exp_flush_o),
    .busy_o(busy_o), .done_o(done_o), .int_err_o(int_err_o)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  int  exp_half = 13;
  longint cyc = 0, t_si = 0, last_period = 0;
  int  frame_cnt = 0, rise_cnt = 0, stray = 0;
  int  edges, stb_n, done_n, idx_bad, si_bad, run_bad, run_len;
  bit  in_frm = 0, cur_s, exp_seen, si_p = 0, sclk_p = 0;
  int  l_edges, l_stb, l_done, l_idx_bad, l_si_bad, l_run_bad;
  bit  l_exp;

  always @(negedge clk) begin
    if (!rst_n) begin
      in_frm = 0; si_p = 0; sclk_p = 0;
    end else begin
      cyc++;
      if (si_o && !si_p) begin
        rise_cnt++;
        last_period = cyc - t_si;
        t_si = cyc;
        in_frm = 1; edges = 0; stb_n = 0; done_n = 0;
        idx_bad = 0; si_bad = 0; run_bad = 0; run_len = 1;
        cur_s = sclk_o; exp_seen = 0;
      end else if (in_frm) begin
        if (sclk_o != cur_s) begin
          if (run_len != exp_half) run_bad++;
          cur_s = sclk_o;
          run_len = 1;
        end else run_len++;
        if (sclk_o && !sclk_p) begin
          edges++;
          if (edges == 1 && !si_o) si_bad++;
          if (edges >= 2 && si_o) si_bad++;
        end
        if (smp_stb_o) begin
          if (sclk_o || int'(pix_idx_o) != stb_n) idx_bad++;
          exp_seen = exp_seen | exp_flush_o;
          stb_n++;
        end
        if (done_o) done_n++;
        if (!busy_o) begin
          in_frm = 0;
          l_edges = edges; l_stb = stb_n; l_done = done_n;
          l_idx_bad = idx_bad; l_si_bad = si_bad; l_run_bad = run_bad;
          l_exp = exp_seen;
          frame_cnt++;
        end
      end else if (smp_stb_o || done_o) begin
        stray++;
      end
      si_p = si_o;
      sclk_p = sclk_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", cyc, 0);
      summary();
    end
  end

  initial begin
    int fc;
    int rb;
    repeat (5) @(negedge clk);
    // R10: quiet outputs under reset
    chk({si_o, sclk_o, busy_o, done_o, smp_stb_o} == 5'b0, "R10 reset state",
        {si_o, sclk_o, busy_o, done_o, smp_stb_o}, 0);
    rst_n = 1'b1;

    // R1: flush frame
    wait (frame_cnt == 1);
    chk(l_edges == N_PIX + 1, "R1 flush edges", l_edges, N_PIX + 1);
    chk(l_stb == 0, "R1 flush strobes", l_stb, 0);
    chk(l_done == 0, "R1 flush done", l_done, 0);
    chk(l_run_bad == 0, "R4 flush phases", l_run_bad, 0);

    // R8: single start held until integration time elapsed
    pulse_start();
    wait (frame_cnt == 2);
    chk(last_period == 9000, "R8 start waits for integration", last_period, 9000);
    chk(l_edges == N_PIX + 1, "R2 edges", l_edges, N_PIX + 1);
    chk(l_done == 1, "R2 done pulse", l_done, 1);
    chk(l_stb == N_PIX, "R5 strobe count", l_stb, N_PIX);
    chk(l_idx_bad == 0, "R5 index order", l_idx_bad, 0);
    chk(l_si_bad == 0, "R3 start pulse timing", l_si_bad, 0);
    chk(l_run_bad == 0, "R4 phase lengths", l_run_bad, 0);
    chk(l_exp == 1'b1, "R9 first frame flag", l_exp, 1);

    // R8: no extra frame; R10 idle pins
    repeat (2000) @(negedge clk);
    chk(frame_cnt == 2, "R8 one frame per request", frame_cnt, 2);
    chk({si_o, sclk_o} == 2'b0, "R10 idle pins", {si_o, sclk_o}, 0);

    pulse_start();
    wait (frame_cnt == 3);
    chk(l_exp == 1'b0, "R9 later frame flag", l_exp, 0);
    chk(l_stb == N_PIX, "R5 strobe count 2", l_stb, N_PIX);

    // vector table: continuous mode
    for (int i = 0; i < 4; i++) begin
      int base;
      div_i = VEC[i].div;
      int_i = VEC[i].itv;
      exp_half = (VEC[i].div < MIN_HALF) ? MIN_HALF : int'(VEC[i].div);
      repeat (3) @(negedge clk);
      chk(int_err_o == VEC[i].err, "R6 range flag", int_err_o, VEC[i].err);
      base = rise_cnt;
      fc = frame_cnt;
      cont_i = 1'b1;
      wait (rise_cnt == base + 2);
      @(negedge clk);
      cont_i = 1'b0;
      chk(last_period == longint'(VEC[i].per), "R7 continuous interval",
          last_period, VEC[i].per);
      wait (frame_cnt == fc + 2);
      rb = l_run_bad;
      chk(rb == 0, "R4 clamped half period", rb, 0);
      chk(l_edges == N_PIX + 1, "R2 edges cont", l_edges, N_PIX + 1);
    end

    chk(stray == 0, "R5 stray strobe or done", stray, 0);
    finished = 1'b1;
    summary();
  end
endmodule